// File: doc/BRIEF.md
# Run-Time Masked Interleave Address Dehasher

The block takes a hashed system address and restores the true channel-select bits. The memory fabric scatters traffic over 2, 4, 8 or 16 channels by XOR-ing each select bit with higher address bits taken from several page granules. Each granule has its own enable. The block undoes that XOR. It does not decide from a mode table which select bits to correct. It builds an eligibility mask at run time: it takes the channel count minus one, shifts it up to bit 8, and opens a gap of zero bits. The size and place of the gap depend on a 1K/2K hash-flavour flag.

Each eligible target bit among 8, 9, 12, 13 and 14 is flipped when the XOR of its enabled companion bits is 1. Every other bit passes through unchanged. An illegal configuration raises the error flag, and the address then passes through as it came in. Results are registered with a one-cycle latency and are qualified by a valid strobe.

Top module: `addr_dehash_unit`

## Requirements
- R1: With a channel count of 2, only bit 8 may be corrected, whatever the flavour flag says.
- R2: With 4, 8 or 16 channels and `flav_1k_i`=0, the eligible set is ((count−1)<<8) with three zero bits inserted at bit 9. This gives {8,12} for 4 channels, {8,12,13} for 8 and {8,12,13,14} for 16.
- R3: With 4, 8 or 16 channels and `flav_1k_i`=1, two zero bits are inserted at bit 10. This gives {8,9} for 4 channels, {8,9,12} for 8 and {8,9,12,13} for 16.
- R4: Companion bits are fixed per target bit. Target 8 uses 16/21/30/40, target 9 uses 17/22/31/41, target 12 uses 18/23/32/42, target 13 uses 19/24/33/43 and target 14 uses 20/25/34/44. Within each group the bits are gated by `hash_en_i[0]` (64K), `[1]` (2M), `[2]` (1G) and `[3]` (1T) in that order.
- R5: An eligible target bit is inverted exactly when the XOR of its enabled companion bits is 1. Companions that cancel, or are disabled, leave it unchanged. With all enables clear the address passes through.
- R6: All address bits other than 8, 9, 12, 13 and 14 reach `addr_o` unchanged.
- R7: `err_o`=1 and `addr_o` equals the input address when any of these holds: `intlv_pos_i` is not 8, `die_cnt_i` exceeds 1, `sock_cnt_i` exceeds 2, or `chan_cnt_i` is not 2, 4, 8 or 16. Otherwise `err_o`=0.
- R8: `vld_o` follows `vld_i` one cycle later. `addr_o` and `err_o` update only for cycles with `vld_i`=1 and hold their values otherwise.
- R9: While `rst_ni` is low, `vld_o`, `err_o` and `addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input address valid |
| addr_i | input | 64 | Hashed address |
| chan_cnt_i | input | 6 | Total interleaved channel count |
| flav_1k_i | input | 1 | 1K hash flavour (else 2K) |
| intlv_pos_i | input | 6 | Interleave start bit position |
| die_cnt_i | input | 3 | Interleaved die count |
| sock_cnt_i | input | 3 | Interleaved socket count |
| hash_en_i | input | 4 | Granule enables: 64K, 2M, 1G, 1T |
| vld_o | output | 1 | Result valid |
| addr_o | output | 64 | Dehashed address |
| err_o | output | 1 | Configuration error |

## Verification
Single companion bits are applied at each channel count under both flavours. The same stimulus must flip a target bit under one flavour and leave it alone under the other, which separates the two gap insertions and shows how the mask grows with the count.

Patterns with several companion bits set show cancellation and per-granule gating. One pattern sets only the 1T companions, and another pairs 1G bits with 16 channels, to check the groups at the top of the address. One pattern starts with a target bit already set, to show that the correction is an inversion and not a set.

Each validity limit is broken on its own, and a legal socket count of 2 is applied, to show that the error flag tracks exactly the stated bounds.

// File: rtl/dh_pkg.sv
package dh_pkg;
  localparam int unsigned N_FIX  = 5;   // correctable target bits
  localparam int unsigned N_GRAN = 4;   // 64K, 2M, 1G, 1T
  localparam int unsigned BASE_POS = 8;

  // target bit k: 8,9 then 12,13,14
  function automatic int unsigned tgt_pos(input int unsigned k);
    return (k < 2) ? BASE_POS + k : BASE_POS + 2 + k;
  endfunction

  // companion bit of granule g for target k
  function automatic int unsigned src_pos(input int unsigned g, input int unsigned k);
    int unsigned base;
    case (g)
      0:       base = 16;
      1:       base = 21;
      2:       base = 30;
      default: base = 40;
    endcase
    return base + k;
  endfunction
endpackage

// File: rtl/dh_mask_gen.sv
module dh_mask_gen #(
  parameter int unsigned CHAN_W   = 6,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned MAX_CHAN = 16,
  parameter int unsigned NAR_POS  = 10,
  parameter int unsigned NAR_CNT  = 2,
  parameter int unsigned WID_POS  = 9,
  parameter int unsigned WID_CNT  = 3
) (
  input  logic [CHAN_W-1:0]      chan_cnt_i,
  input  logic                   flav_1k_i,
  output logic                   chan_ok_o,
  output logic [dh_pkg::N_FIX-1:0] sel_o
);
  import dh_pkg::*;

  // open cnt zero bits at pos, upper part moves up
  function automatic logic [VEC_W-1:0] ins_gap(input logic [VEC_W-1:0] v,
                                               input int unsigned pos,
                                               input int unsigned cnt);
    logic [VEC_W-1:0] lo;
    lo = (VEC_W'(1) << pos) - VEC_W'(1);
    return (v & lo) | ((v & ~lo) << cnt);
  endfunction

  logic [VEC_W-1:0] raw_vec, gap_vec;
  logic             narrow;

  always_comb begin
    chan_ok_o = $onehot(chan_cnt_i) && (chan_cnt_i >= CHAN_W'(2)) &&
                (chan_cnt_i <= CHAN_W'(MAX_CHAN));
    raw_vec   = VEC_W'(chan_cnt_i - CHAN_W'(1)) << BASE_POS;
    narrow    = flav_1k_i && (chan_cnt_i >= CHAN_W'(4));
    gap_vec   = narrow ? ins_gap(raw_vec, NAR_POS, NAR_CNT)
                       : ins_gap(raw_vec, WID_POS, WID_CNT);
    if (!chan_ok_o) gap_vec = '0;
  end

  for (genvar k = 0; k < N_FIX; k++) begin : g_sel
    assign sel_o[k] = gap_vec[tgt_pos(k)];
  end
endmodule

// File: rtl/dh_bit_fix.sv
module dh_bit_fix #(
  parameter int unsigned N_GRAN = 4
) (
  input  logic              sel_i,
  input  logic [N_GRAN-1:0] src_i,
  input  logic [N_GRAN-1:0] en_i,
  output logic              flip_o
);
  assign flip_o = sel_i & (^(src_i & en_i));
endmodule

// File: rtl/dh_cfg_check.sv
module dh_cfg_check #(
  parameter int unsigned POS_W    = 6,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned POS_REQ  = 8,
  parameter int unsigned MAX_DIE  = 1,
  parameter int unsigned MAX_SOCK = 2
) (
  input  logic [POS_W-1:0] intlv_pos_i,
  input  logic [CNT_W-1:0] die_cnt_i,
  input  logic [CNT_W-1:0] sock_cnt_i,
  input  logic             chan_ok_i,
  output logic             err_o
);
  assign err_o = (intlv_pos_i != POS_W'(POS_REQ)) ||
                 (die_cnt_i  >  CNT_W'(MAX_DIE))  ||
                 (sock_cnt_i >  CNT_W'(MAX_SOCK)) ||
                 !chan_ok_i;
endmodule

// File: rtl/addr_dehash_unit.sv
module addr_dehash_unit #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned POS_W  = 6,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned VEC_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [CHAN_W-1:0]         chan_cnt_i,
  input  logic                      flav_1k_i,
  input  logic [POS_W-1:0]          intlv_pos_i,
  input  logic [CNT_W-1:0]          die_cnt_i,
  input  logic [CNT_W-1:0]          sock_cnt_i,
  input  logic [dh_pkg::N_GRAN-1:0] hash_en_i,
  output logic                      vld_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      err_o
);
  import dh_pkg::*;

  logic             chan_ok, cfg_err;
  logic [N_FIX-1:0] sel, flip;
  logic [ADDR_W-1:0] fix_mask, addr_nxt;

  dh_mask_gen #(.CHAN_W(CHAN_W), .VEC_W(VEC_W)) u_mask (
    .chan_cnt_i (chan_cnt_i),
    .flav_1k_i  (flav_1k_i),
    .chan_ok_o  (chan_ok),
    .sel_o      (sel)
  );

  dh_cfg_check #(.POS_W(POS_W), .CNT_W(CNT_W)) u_cfg (
    .intlv_pos_i (intlv_pos_i),
    .die_cnt_i   (die_cnt_i),
    .sock_cnt_i  (sock_cnt_i),
    .chan_ok_i   (chan_ok),
    .err_o       (cfg_err)
  );

  // companions sit above every target, so all fixes evaluate in parallel
  for (genvar k = 0; k < N_FIX; k++) begin : g_fix
    logic [N_GRAN-1:0] src;
    for (genvar g = 0; g < N_GRAN; g++) begin : g_src
      assign src[g] = addr_i[src_pos(g, k)];
    end
    dh_bit_fix #(.N_GRAN(N_GRAN)) u_fix (
      .sel_i  (sel[k]),
      .src_i  (src),
      .en_i   (hash_en_i),
      .flip_o (flip[k])
    );
  end

  always_comb begin
    fix_mask = '0;
    for (int k = 0; k < N_FIX; k++) fix_mask[tgt_pos(k)] = flip[k];
    addr_nxt = cfg_err ? addr_i : (addr_i ^ fix_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        addr_o <= addr_nxt;
        err_o  <= cfg_err;
      end
    end
  end
endmodule

// File: rtl/addr_dehash_unit_chk.sv
module addr_dehash_unit_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned POS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CHAN_W-1:0] chan_cnt_i,
  input logic [POS_W-1:0]  intlv_pos_i,
  input logic [3:0]        hash_en_i,
  input logic              vld_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              err_o
);
  localparam logic [ADDR_W-1:0] TGT_MASK =
    (ADDR_W'(1) << 8) | (ADDR_W'(1) << 9) | (ADDR_W'(1) << 12) |
    (ADDR_W'(1) << 13) | (ADDR_W'(1) << 14);

  a_r8_vld_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r8_vld_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(addr_o) && $stable(err_o)));
  a_r7_bad_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && intlv_pos_i != POS_W'(8)) |=> (err_o && addr_o == $past(addr_i)));
  a_r6_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (((addr_o ^ $past(addr_i)) & ~TGT_MASK) == '0));
  a_r5_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && hash_en_i == 4'b0) |=> (addr_o == $past(addr_i)));
  a_r1_two_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && chan_cnt_i == CHAN_W'(2)) |=> (addr_o[14:9] == $past(addr_i[14:9])));
endmodule

bind addr_dehash_unit addr_dehash_unit_chk #(
  .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .POS_W(POS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vld_i       (vld_i),
  .addr_i      (addr_i),
  .chan_cnt_i  (chan_cnt_i),
  .intlv_pos_i (intlv_pos_i),
  .hash_en_i   (hash_en_i),
  .vld_o       (vld_o),
  .addr_o      (addr_o),
  .err_o       (err_o)
);

// File: tb/addr_dehash_unit_test.sv
module addr_dehash_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic [5:0]  chan_cnt_i = 6'd2;
  logic        flav_1k_i = 1'b0;
  logic [5:0]  intlv_pos_i = 6'd8;
  logic [2:0]  die_cnt_i = 3'd1;
  logic [2:0]  sock_cnt_i = 3'd1;
  logic [3:0]  hash_en_i = 4'hF;
  logic        vld_o, err_o;
  logic [63:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  addr_dehash_unit uut (
    .clk_i, .rst_ni, .vld_i, .addr_i, .chan_cnt_i, .flav_1k_i,
    .intlv_pos_i, .die_cnt_i, .sock_cnt_i, .hash_en_i,
    .vld_o, .addr_o, .err_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [63:0] addr;
    logic [5:0]  chan;
    logic        f1k;
    logic [5:0]  pos;
    logic [2:0]  dies;
    logic [2:0]  socks;
    logic [3:0]  en;
    logic [63:0] exp_addr;
    logic        exp_err;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 64'h10000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h10100, 1'b0},   // R1 bit8 via 16
    '{4'd1, 64'h20000, 6'd2, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h20000, 1'b0},   // R1 bit9 not eligible
    '{4'd3, 64'h20000, 6'd4, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h20200, 1'b0},   // R3 4ch 1K bit9
    '{4'd2, 64'h20000, 6'd4, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h20000, 1'b0},   // R2 4ch 2K no bit9
    '{4'd2, 64'h40000, 6'd4, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h41000, 1'b0},   // R2 4ch 2K bit12
    '{4'd3, 64'h40000, 6'd4, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h40000, 1'b0},   // R3 4ch 1K no bit12
    '{4'd3, 64'h80000, 6'd8, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h80000, 1'b0},   // R3 8ch 1K no bit13
    '{4'd2, 64'h80000, 6'd8, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h82000, 1'b0},   // R2 8ch 2K bit13
    '{4'd2, 64'h100000, 6'd16, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h104000, 1'b0}, // R2 16ch 2K bit14
    '{4'd3, 64'h100000, 6'd16, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h100000, 1'b0}, // R3 16ch 1K no bit14
    '{4'd4, 64'h00001F0000000000, 6'd16, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF,
            64'h00001F0000007100, 1'b0},                                         // R4 1T group
    '{4'd4, 64'h00001F0000000000, 6'd16, 1'b0, 6'd8, 3'd1, 3'd1, 4'h7,
            64'h00001F0000000000, 1'b0},                                         // R4 1T gated off
    '{4'd5, 64'h210000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h210000, 1'b0},  // R5 cancel
    '{4'd5, 64'h210000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd1, 4'h2, 64'h210100, 1'b0},  // R5 2M only
    '{4'd5, 64'h10100, 6'd2, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h10000, 1'b0},    // R5 invert set bit
    '{4'd5, 64'h10000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd1, 4'h0, 64'h10000, 1'b0},    // R5 all off
    '{4'd4, 64'h3C0000000, 6'd16, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF, 64'h3C0003300, 1'b0}, // R4 1G
    '{4'd6, 64'hA5A5000000000001, 6'd8, 1'b1, 6'd8, 3'd1, 3'd1, 4'hF,
            64'hA5A5000000000001, 1'b0},                                         // R6 other bits
    '{4'd7, 64'h10000, 6'd2, 1'b0, 6'd9, 3'd1, 3'd1, 4'hF, 64'h10000, 1'b1},    // R7 pos
    '{4'd7, 64'h10000, 6'd2, 1'b0, 6'd8, 3'd2, 3'd1, 4'hF, 64'h10000, 1'b1},    // R7 dies
    '{4'd7, 64'h10000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd3, 4'hF, 64'h10000, 1'b1},    // R7 sockets
    '{4'd7, 64'h10000, 6'd2, 1'b0, 6'd8, 3'd1, 3'd2, 4'hF, 64'h10100, 1'b0},    // R7 two sockets legal
    '{4'd7, 64'h10000, 6'd6, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h10000, 1'b1},    // R7 six channels
    '{4'd7, 64'h10000, 6'd32, 1'b0, 6'd8, 3'd1, 3'd1, 4'hF, 64'h10000, 1'b1}    // R7 32 channels
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    vld_i       = 1'b1;
    addr_i      = v.addr;
    chan_cnt_i  = v.chan;
    flav_1k_i   = v.f1k;
    intlv_pos_i = v.pos;
    die_cnt_i   = v.dies;
    sock_cnt_i  = v.socks;
    hash_en_i   = v.en;
    @(negedge clk_i);
    vld_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk_i);
    check("R9", "vld_o", {63'b0, vld_o}, 64'd0);
    check("R9", "addr_o", addr_o, 64'd0);
    check("R9", "err_o", {63'b0, err_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d addr", i),
            addr_o, TBL[i].exp_addr);
      check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d err", i),
            {63'b0, err_o}, {63'b0, TBL[i].exp_err});
      check("R8", $sformatf("vec %0d vld", i), {63'b0, vld_o}, 64'd1);
    end

    // R8 hold while idle, valid drops
    addr_i     = 64'h10000;
    chan_cnt_i = 6'd2;
    @(negedge clk_i);
    check("R8", "vld_o low", {63'b0, vld_o}, 64'd0);
    check("R8", "addr hold", addr_o, 64'h10000);
    check("R8", "err hold", {63'b0, err_o}, 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule